// File: doc/BRIEF.md
# Bidirectional-Port Up/Down Binary Counter

This block is a fully synchronous binary counter, 8 bits wide by default, that counts up or down. One bus carries both the value to preset and the present count. A parallel load copies the bus into the counter. When the chip is selected and its output is enabled, the block drives its count onto the same bus. All changes happen on the rising clock edge. The one exception is the master reset, which clears the counter at once with no clock.

Two active-low count enables gate counting. One is a parallel enable and one is a trickle enable. The active-low terminal-count output depends only on the trickle enable, the direction and the count. Because of this, wider counters are built by wiring each stage's terminal count into the trickle enable of the next stage. The shared bus is modelled as three signals: data in, data out and a drive-enable. The drive-enable would steer a tri-state pad at the chip boundary. The control pins are plain level inputs with no handshake. A parallel load takes whatever is on the bus in that cycle.

Top module: `bidir_updown_counter`

## Requirements
- R1: While `rst_n` is low, the count is zero. The count becomes zero as soon as `rst_n` falls, without waiting for a clock edge.
- R2: At a rising edge with `srst_n` low, the count becomes zero. This takes priority over load and count.
- R3: At a rising edge with `srst_n` high and `load_n` low, the count takes the value of `bus_in`. This takes priority over counting.
- R4: At a rising edge with `srst_n` and `load_n` high, both enables low and `up` high, the count goes up by one. All ones wraps to zero.
- R5: Under the same conditions with `up` low, the count goes down by one. Zero wraps to all ones.
- R6: If `cnt_en_p_n` or `cnt_en_t_n` is high and neither reset nor load is active, the count holds its value.
- R7: `tc_n` is low exactly when `cnt_en_t_n` is low and one of these holds: `up` is high and the count is all ones, or `up` is low and the count is zero. `cnt_en_p_n` has no effect on `tc_n`.
- R8: `bus_oe` is high exactly when `cs_n` is low, `oe_n` is low and `load_n` is high. While `bus_oe` is high, `bus_out` equals the count. While `bus_oe` is low, `bus_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous master clear, active low |
| srst_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Parallel load from bus, active low |
| cnt_en_p_n | input | 1 | Parallel count enable, active low |
| cnt_en_t_n | input | 1 | Trickle count enable, active low; also gates tc_n |
| up | input | 1 | 1 = count up, 0 = count down |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| bus_in | input | WIDTH | Data sampled from the shared bus |
| bus_out | output | WIDTH | Count presented to the shared bus |
| bus_oe | output | 1 | Drive-enable for the shared bus pad |
| tc_n | output | 1 | Terminal count, active low |

## Verification
Two situations are hard to reach from the ports. The first is the master reset acting between clock edges. The bench brings the counter to a non-zero value, drops `rst_n` midway through the low phase of the clock and reads the bus before the next rising edge. The second is the terminal-count decode at both extremes. Reaching those by counting would be slow, so the bench loads all ones and zero directly and parks the counter with the parallel enable off. It then sweeps the trickle enable and the direction and checks that the parallel enable has no effect on `tc_n`. The vector table also checks the wraps at both ends and the priority of reset over load and of load over count.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_LOAD  = 3'd2,
    OP_INC   = 3'd3,
    OP_DEC   = 3'd4
  } ctr_op_e;
endpackage

// File: rtl/ctr_ctrl.sv
module ctr_ctrl
  import ctr_pkg::*;
(
  input  logic    srst_n,
  input  logic    load_n,
  input  logic    cnt_en_p_n,
  input  logic    cnt_en_t_n,
  input  logic    up,
  output ctr_op_e op
);
  logic count_ok;
  assign count_ok = ~cnt_en_p_n & ~cnt_en_t_n;

  // priority: sync clear, load, count, hold
  always_comb begin
    if (!srst_n)       op = OP_CLEAR;
    else if (!load_n)  op = OP_LOAD;
    else if (count_ok) op = up ? OP_INC : OP_DEC;
    else               op = OP_HOLD;
  end
endmodule

// File: rtl/ctr_state.sv
module ctr_state
  import ctr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctr_op_e          op,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] count_q, count_d;

  always_comb begin
    unique case (op)
      OP_CLEAR: count_d = '0;
      OP_LOAD:  count_d = din;
      OP_INC:   count_d = count_q + ONE;
      OP_DEC:   count_d = count_q - ONE;
      default:  count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;
endmodule

// File: rtl/ctr_tc.sv
module ctr_tc #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] count,
  input  logic             up,
  input  logic             cnt_en_t_n,
  output logic             tc_n
);
  logic at_top, at_bot, edge_hit;
  assign at_top   = &count;
  assign at_bot   = ~|count;
  assign edge_hit = up ? at_top : at_bot;
  assign tc_n     = ~(edge_hit & ~cnt_en_t_n);
endmodule

// File: rtl/ctr_bus.sv
module ctr_bus #(
  parameter int WIDTH = 8
) (
  input  logic             cs_n,
  input  logic             oe_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] count,
  output logic             bus_oe,
  output logic [WIDTH-1:0] bus_out
);
  // a pending load keeps the pad released so external data can arrive
  assign bus_oe  = ~cs_n & ~oe_n & load_n;
  assign bus_out = bus_oe ? count : '0;
endmodule

// File: rtl/bidir_updown_counter.sv
module bidir_updown_counter
  import ctr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst_n,
  input  logic             load_n,
  input  logic             cnt_en_p_n,
  input  logic             cnt_en_t_n,
  input  logic             up,
  input  logic             cs_n,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_oe,
  output logic             tc_n
);
  ctr_op_e          op;
  logic [WIDTH-1:0] count_q;

  ctr_ctrl u_ctrl (
    .srst_n     (srst_n),
    .load_n     (load_n),
    .cnt_en_p_n (cnt_en_p_n),
    .cnt_en_t_n (cnt_en_t_n),
    .up         (up),
    .op         (op)
  );

  ctr_state #(.WIDTH(WIDTH)) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .din   (bus_in),
    .count (count_q)
  );

  ctr_tc #(.WIDTH(WIDTH)) u_tc (
    .count      (count_q),
    .up         (up),
    .cnt_en_t_n (cnt_en_t_n),
    .tc_n       (tc_n)
  );

  ctr_bus #(.WIDTH(WIDTH)) u_bus (
    .cs_n    (cs_n),
    .oe_n    (oe_n),
    .load_n  (load_n),
    .count   (count_q),
    .bus_oe  (bus_oe),
    .bus_out (bus_out)
  );
endmodule

// File: rtl/bidir_updown_counter_chk.sv
module bidir_updown_counter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             srst_n,
  input logic             load_n,
  input logic             cnt_en_p_n,
  input logic             cnt_en_t_n,
  input logic             up,
  input logic             cs_n,
  input logic             oe_n,
  input logic [WIDTH-1:0] bus_in,
  input logic             bus_oe,
  input logic             tc_n,
  input logic [WIDTH-1:0] count_q
);
  AST_MASTER_CLEAR: assert property (@(posedge clk) !rst_n |-> count_q == '0); // R1
  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) !srst_n |=> count_q == '0); // R2
  AST_LOAD_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n) (srst_n && !load_n) |=> count_q == $past(bus_in)); // R3
  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n) (srst_n && load_n && !cnt_en_p_n && !cnt_en_t_n && up) |=> count_q == $past(count_q) + WIDTH'(1)); // R4
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n) (srst_n && load_n && !cnt_en_p_n && !cnt_en_t_n && !up) |=> count_q == $past(count_q) - WIDTH'(1)); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (srst_n && load_n && (cnt_en_p_n || cnt_en_t_n)) |=> $stable(count_q)); // R6
  AST_TC_NEEDS_TRICKLE: assert property (@(posedge clk) disable iff (!rst_n) !tc_n |-> (!cnt_en_t_n && (count_q == '0 || count_q == '1))); // R7
  AST_BUS_DRIVE_GATED: assert property (@(posedge clk) disable iff (!rst_n) bus_oe |-> (!cs_n && !oe_n && load_n)); // R8
endmodule

bind bidir_updown_counter bidir_updown_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .srst_n     (srst_n),
  .load_n     (load_n),
  .cnt_en_p_n (cnt_en_p_n),
  .cnt_en_t_n (cnt_en_t_n),
  .up         (up),
  .cs_n       (cs_n),
  .oe_n       (oe_n),
  .bus_in     (bus_in),
  .bus_oe     (bus_oe),
  .tc_n       (tc_n),
  .count_q    (count_q)
);

// File: tb/sim_bidir_updown_counter.sv
`timescale 1ns/1ps
module sim_bidir_updown_counter;
  logic       clk = 1'b0;
  logic       rst_n, srst_n, load_n, cnt_en_p_n, cnt_en_t_n, up, cs_n, oe_n;
  logic [7:0] bus_in;
  logic [7:0] bus_out;
  logic       bus_oe, tc_n;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  bidir_updown_counter #(.WIDTH(8)) u0 (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n), .load_n(load_n),
    .cnt_en_p_n(cnt_en_p_n), .cnt_en_t_n(cnt_en_t_n), .up(up),
    .cs_n(cs_n), .oe_n(oe_n), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .tc_n(tc_n)
  );

  typedef struct packed {
    logic       srst_n;
    logic       load_n;
    logic       cep_n;
    logic       cet_n;
    logic       up;
    logic [7:0] din;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h10, 8'h10}, // R3 load
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h11}, // R4 up
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h12}, // R4 up
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h11}, // R5 down
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h11}, // R6 parallel off
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h11}, // R6 trickle off
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF}, // R3 load top
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00}, // R4 wrap up
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF}, // R5 wrap down
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h33, 8'h00}, // R2 beats load and count
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h5A, 8'h5A}, // R3 beats count
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h59}  // R5 down
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // read mode: bus driven, counter parked
  task automatic park();
    srst_n = 1'b1; load_n = 1'b1; cnt_en_p_n = 1'b1; cnt_en_t_n = 1'b1;
    cs_n = 1'b0; oe_n = 1'b0;
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    srst_n = v.srst_n; load_n = v.load_n; cnt_en_p_n = v.cep_n;
    cnt_en_t_n = v.cet_n; up = v.up; bus_in = v.din;
    @(posedge clk);
    #2;
    park();
    #1;
  endtask

  initial begin
    #1_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; up = 1'b1; bus_in = 8'h00;
    park();
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset count", {24'd0, bus_out}, 32'h00);
    check("R8 reset drive", {31'd0, bus_oe}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check($sformatf("vector %0d R2/R3/R4/R5/R6", i), {24'd0, bus_out}, {24'd0, VECS[i].exp});
    end

    // R1: clear between edges
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    check("R1 async clear before edge", {24'd0, bus_out}, 32'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // R7 at the top
    apply('{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, 8'hFF});
    up = 1'b1; cnt_en_t_n = 1'b0; cnt_en_p_n = 1'b1; #1;
    check("R7 top, trickle on, parallel off", {31'd0, tc_n}, 32'd0);
    cnt_en_t_n = 1'b1; cnt_en_p_n = 1'b0; #1;
    check("R7 top, trickle off", {31'd0, tc_n}, 32'd1);
    cnt_en_p_n = 1'b1; cnt_en_t_n = 1'b0; up = 1'b0; #1;
    check("R7 top, down", {31'd0, tc_n}, 32'd1);
    cnt_en_t_n = 1'b1; up = 1'b1; #1;

    // R7 at the bottom
    apply('{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00});
    up = 1'b0; cnt_en_t_n = 1'b0; #1;
    check("R7 bottom, down", {31'd0, tc_n}, 32'd0);
    up = 1'b1; #1;
    check("R7 bottom, up", {31'd0, tc_n}, 32'd1);
    cnt_en_t_n = 1'b1; #1;

    // R8 drive control, count 0x3C parked
    apply('{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h3C, 8'h3C});
    check("R8 driven", {23'd0, bus_oe, bus_out}, {23'd0, 1'b1, 8'h3C});
    cs_n = 1'b1; #1;
    check("R8 deselected", {23'd0, bus_oe, bus_out}, 32'h000);
    cs_n = 1'b0; oe_n = 1'b1; #1;
    check("R8 output disabled", {23'd0, bus_oe, bus_out}, 32'h000);
    oe_n = 1'b0; load_n = 1'b0; #1;
    check("R8 load pending", {23'd0, bus_oe, bus_out}, 32'h000);
    load_n = 1'b1; #1;
    check("R8 re-driven", {23'd0, bus_oe, bus_out}, {23'd0, 1'b1, 8'h3C});

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule